// File: doc/BRIEF.md
# Latched Serial-to-Parallel Register

This block converts a serial bit stream into a parallel word and holds that word steady while the next one arrives. Bits enter a chain of flops on the rising edge of a shift clock. The output latch copies the whole chain on the rising edge of a separate latch clock. Because of this split, the parallel pins change only when the user strobes the latch clock, never in the middle of a word.

The parallel pins are driven from the latch through gated drivers. When the active-low output enable is high, the pins float to high impedance, and a companion flag reports whether the drivers are on. An active-low clear empties the shift chain at once, without waiting for a clock, and leaves the latch untouched. The last flop of the chain also drives a cascade pin. That pin can feed the serial input of a further copy, so several blocks can be chained into one longer register.

Top module: `latched_sipo`

## Requirements
- R1: On each rising edge of `shift_clk` while `clr_n` is high, `din` is stored in chain bit 0 and every chain bit i moves to bit i+1.
- R2: `chain_out` always equals the top chain bit (bit W-1), so it changes on the same rising `shift_clk` edge that moves a bit into that position.
- R3: On each rising edge of `latch_clk`, the output latch takes a copy of all W chain bits. Latch bit i holds chain bit i.
- R4: Driving `clr_n` low forces every chain bit to 0 immediately, with no clock. While `clr_n` stays low, rising `shift_clk` edges have no effect.
- R5: The output latch changes only on a rising `latch_clk` edge. Neither `clr_n` nor `shift_clk` alters it.
- R6: With `out_en_n` low, `q` shows the latch contents and `q_driven` is 1. With `out_en_n` high, `q` is high impedance and `q_driven` is 0.
- R7: When `shift_clk` and `latch_clk` rise together, the latch receives the chain contents from before that edge.
- R8: Ordering: shifting in 1 and then 0 leaves bit 1 = 1 and bit 0 = 0. After W shifts, the first bit shifted in sits at `q[W-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Rising-edge clock of the shift chain |
| latch_clk | input | 1 | Rising-edge clock of the output latch |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| out_en_n | input | 1 | Parallel output enable, active low |
| din | input | 1 | Serial data into chain bit 0 |
| q | output | W (8) | Parallel outputs from the latch, high impedance when disabled |
| q_driven | output | 1 | 1 while the parallel drivers are on |
| chain_out | output | 1 | Top chain bit, used for cascading |

## Verification
`chain_out` is due right after the `shift_clk` edge that moves a bit into the top position. `q` is due right after a `latch_clk` edge. `q_driven` and the float state of `q` follow `out_en_n` with no clock at all. Clear acts as soon as `clr_n` falls. The bench raises each clock on a falling edge of its own 100 MHz reference and samples one reference period later. It also samples while a clear is still held, so every result is read after it settles and before the next stimulus.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;

    // Default word width of the converter
    localparam int unsigned SIPO_W = 8;

    // Driver state of the parallel pins
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drive_e;

    // Active-low enable to driver state
    function automatic drive_e drive_from_en_n(input logic en_n);
        return en_n ? DRV_OFF : DRV_ON;
    endfunction

endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         din,
    output logic [W-1:0] chain
);
    // Per-bit flops; bit 0 takes the serial input, each later bit its neighbour
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic d_in;
        if (i == 0) begin : g_head
            assign d_in = din;
        end else begin : g_body
            assign d_in = chain[i-1];
        end
        always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) chain[i] <= 1'b0;
            else        chain[i] <= d_in;
        end
    end
endmodule

// File: rtl/sipo_store_stage.sv
module sipo_store_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // No reset: the latch keeps its word across chain clears
    always_ff @(posedge clk) begin
        q <= d;
    end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate
    import sipo_latch_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         driven
);
    drive_e state;
    assign state  = drive_from_en_n(en_n);
    assign driven = (state == DRV_ON);
    assign q      = (state == DRV_ON) ? d : {W{1'bz}};
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
    import sipo_latch_pkg::*;
#(
    parameter int unsigned W = SIPO_W
) (
    input  logic         shift_clk,
    input  logic         latch_clk,
    input  logic         clr_n,
    input  logic         out_en_n,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         q_driven,
    output logic         chain_out
);
    localparam int unsigned TOP = W - 1;

    logic [W-1:0] sh_q;
    logic [W-1:0] lat_q;

    sipo_shift_stage #(.W(W)) u_shift (
        .clk   (shift_clk),
        .clr_n (clr_n),
        .din   (din),
        .chain (sh_q)
    );

    sipo_store_stage #(.W(W)) u_store (
        .clk (latch_clk),
        .d   (sh_q),
        .q   (lat_q)
    );

    sipo_out_gate #(.W(W)) u_gate (
        .en_n   (out_en_n),
        .d      (lat_q),
        .q      (q),
        .driven (q_driven)
    );

    assign chain_out = sh_q[TOP];
endmodule

// File: rtl/latched_sipo_chk.sv
module latched_sipo_chk #(
    parameter int unsigned W = 8
) (
    input logic         shift_clk,
    input logic         latch_clk,
    input logic         clr_n,
    input logic         din,
    input logic [W-1:0] sh_q,
    input logic [W-1:0] lat_q
);
    // Set by a clear, dropped by the next shift edge
    logic       fresh = 1'b1;
    logic       sh_seen = 1'b0;
    logic       lat_seen = 1'b0;
    logic [1:0] lat_cnt = 2'd0;

    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) fresh <= 1'b1;
        else        fresh <= 1'b0;
    end

    always_ff @(posedge shift_clk) sh_seen <= 1'b1;

    always_ff @(posedge latch_clk) begin
        lat_seen <= 1'b1;
        lat_cnt  <= lat_cnt + 2'd1;
    end

    // R1
    shift_step_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (sh_seen && !fresh) |-> (sh_q == {$past(sh_q[W-2:0]), $past(din)}));

    // R4
    clear_zero_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        fresh |-> (sh_q == '0));

    // R5
    latch_hold_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (sh_seen && lat_cnt == $past(lat_cnt)) |-> $stable(lat_q));

    // R3, R7
    latch_capture_chk: assert property (@(posedge latch_clk) disable iff (!clr_n)
        lat_seen |-> (lat_q == $past(sh_q)));
endmodule

bind latched_sipo latched_sipo_chk #(.W(W)) u_chk (
    .shift_clk (shift_clk),
    .latch_clk (latch_clk),
    .clr_n     (clr_n),
    .din       (din),
    .sh_q      (sh_q),
    .lat_q     (lat_q)
);

// File: tb/latched_sipo_bench.sv
module latched_sipo_bench;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         shift_clk = 1'b0;
    logic         latch_clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         out_en_n = 1'b0;
    logic         din = 1'b0;
    logic [W-1:0] q;
    logic         q_driven;
    logic         chain_out;

    logic [W-1:0] m_sh = '0;
    logic [W-1:0] m_lat = '0;
    logic         lat_valid = 1'b0;
    int           n_checks = 0;
    int           n_fails = 0;

    always #5 clk = ~clk;

    latched_sipo #(.W(W)) u_latched_sipo (
        .shift_clk (shift_clk),
        .latch_clk (latch_clk),
        .clr_n     (clr_n),
        .out_en_n  (out_en_n),
        .din       (din),
        .q         (q),
        .q_driven  (q_driven),
        .chain_out (chain_out)
    );

    function automatic logic [W-1:0] model_shift(input logic [W-1:0] s, input logic b);
        return {s[W-2:0], b};
    endfunction

    task automatic check_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check_val({req, " R6 drive flag"}, W'(q_driven), W'(!out_en_n));
        check_val({req, " R2 cascade"}, W'(chain_out), W'(m_sh[W-1]));
        if (!out_en_n && lat_valid) check_val({req, " R6 q"}, q, m_lat);
    endtask

    // Raise the selected clocks together; model uses pre-edge chain
    task automatic edge_op(input logic sh, input logic lt, input logic d, input string req);
        logic [W-1:0] prev;
        @(negedge clk);
        din = d;
        @(negedge clk);
        prev = m_sh;
        if (sh && clr_n) m_sh = model_shift(m_sh, d);
        if (lt) begin
            m_lat = prev;
            lat_valid = 1'b1;
        end
        shift_clk = sh;
        latch_clk = lt;
        @(negedge clk);
        shift_clk = 1'b0;
        latch_clk = 1'b0;
        check_all(req);
    endtask

    task automatic clear_op(input logic shift_while_low);
        @(negedge clk);
        clr_n = 1'b0;
        m_sh = '0;
        @(negedge clk);
        // R4: chain empty at once
        check_val("R4 clear immediate", W'(chain_out), '0);
        if (shift_while_low) begin
            din = 1'b1;
            shift_clk = 1'b1;
            @(negedge clk);
            shift_clk = 1'b0;
            check_val("R4 shift ignored in clear", W'(chain_out), '0);
        end
        // R5: latch unchanged by clear
        if (!out_en_n && lat_valid) check_val("R5 latch kept in clear", q, m_lat);
        @(negedge clk);
        clr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // Reset state: chain empty, drivers on
        check_val("R4 reset chain_out", W'(chain_out), '0);
        check_val("R6 reset drive flag", W'(q_driven), W'(1));
        clr_n = 1'b1;

        // R8 two-stage ordering
        edge_op(1'b1, 1'b0, 1'b1, "R1 shift one");
        edge_op(1'b1, 1'b0, 1'b0, "R1 shift zero");
        edge_op(1'b0, 1'b1, 1'b0, "R3 latch");
        check_val("R8 two-stage", W'(q[1:0]), W'(2'b10));

        // R8 full word, first bit lands at top
        word = 8'hA7;
        for (int i = W - 1; i >= 0; i--) edge_op(1'b1, 1'b0, word[i], "R1 word");
        edge_op(1'b0, 1'b1, 1'b0, "R3 word latch");
        check_val("R8 word order", q, 8'hA7);

        // R7 simultaneous edges
        edge_op(1'b1, 1'b1, 1'b0, "R7 same edge");
        check_val("R7 pre-edge capture", q, 8'hA7);
        edge_op(1'b0, 1'b1, 1'b0, "R3 relatch");
        check_val("R3 shifted copy", q, 8'h4E);

        // R5 clear leaves latch; R4 ignores shifts while low
        clear_op(1'b1);
        check_val("R5 after clear", q, 8'h4E);
        edge_op(1'b0, 1'b1, 1'b0, "R3 latch cleared chain");
        check_val("R4 cleared word", q, 8'h00);

        // R6 float
        @(negedge clk);
        out_en_n = 1'b1;
        @(negedge clk);
        check_val("R6 disabled flag", W'(q_driven), '0);
        out_en_n = 1'b0;
        @(negedge clk);
        check_val("R6 re-enabled", q, 8'h00);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0, 1, 2, 3: edge_op(1'b1, 1'b0, 1'($urandom), "R1 random shift");
                4:          edge_op(1'b0, 1'b1, 1'b0, "R3 random latch");
                5:          edge_op(1'b1, 1'b1, 1'($urandom), "R7 random both");
                6: begin
                    @(negedge clk);
                    out_en_n = ~out_en_n;
                    @(negedge clk);
                    check_all("R6 random enable");
                end
                default:    clear_op(1'($urandom));
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule